// File: doc/BRIEF.md
# Rational-Unit Command Dispatcher

This block sits between a command source and a set of rational-arithmetic execution units. Each command is one 32-bit word. A 4-bit operation code in the word selects one operation, and three 4-bit fields name the two source registers (A and B) and the destination register (C). When a word arrives while the block is idle, the block captures the register numbers and raises the one-hot enable line for the selected operation. It then holds that line until the execution units report completion on a shared done line.

While an operation is running, the block shows busy and ignores further words, so the source simply waits for busy to fall. A no-operation code completes at once and is not gated by completion. Codes that are not in the map are accepted and turned into no-ops, and the block pulses a flag for them. A watchdog ends a command that never receives completion and reports the timeout.

Top module: `cwd_dispatch`

## Requirements
- R1: A word is accepted on a clock edge where `word_vld_i` is high and `busy_o` is low. For an operation code that is in the map and is not zero, `busy_o` is high and exactly the bit `op_en_o[code]` is set from that edge on. The code is taken from `word_i[21:18]`.
- R2: The operation map is: 0 no-op, 1 common-divisor, 2 factor cast, 3 reciprocal swap, 4 multiply, 6 add, 7 subtract, 12 move, 13 copy, 14 load and 15 store. Each of these codes drives its own enable bit.
- R3: On acceptance, `sel_a_o` takes `word_i[3:0]`, `sel_b_o` takes `word_i[7:4]` and `sel_c_o` takes `word_i[11:8]`.
- R4: Bits 31:22, 17:12 of the word have no effect on the enables or the selects.
- R5: In any cycle where `done_i` is high, every enable bit other than bit 0 is low.
- R6: `done_i` high during a busy cycle returns the block to idle on the next edge: `busy_o` falls and the enables go to zero.
- R7: Words that arrive while busy are ignored. The selects and the running enable do not change until the command ends.
- R8: A no-op word (code 0) raises `op_en_o[0]` for exactly one cycle after acceptance, even with `done_i` high. It never raises `busy_o`.
- R9: Codes 5, 8, 9, 10 and 11 raise no enable and no busy. They raise `bad_op_o` for the one cycle after acceptance.
- R10: If `done_i` stays low for TMO_CYC (default 32) busy cycles, the block returns to idle and raises `timeout_o` for one cycle.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| word_i | input | 32 | Command word |
| word_vld_i | input | 1 | Command word valid |
| done_i | input | 1 | Combined completion line from execution units |
| op_en_o | output | 16 | One-hot operation enables |
| sel_a_o | output | 4 | Source register A number |
| sel_b_o | output | 4 | Source register B number |
| sel_c_o | output | 4 | Destination register number |
| busy_o | output | 1 | Command in progress |
| bad_op_o | output | 1 | One-cycle pulse for an unmapped code |
| timeout_o | output | 1 | One-cycle pulse when the watchdog ends a command |

## Verification
Every mapped non-zero code is sent with a distinct set of register fields. This shows that each code reaches its own enable bit and that the three fields are not swapped. A word with the reserved bits all set separates field extraction from stray bit decoding. A no-op sent with completion already high, each unmapped code, a second word sent during a running command, and a command left without completion each exercise a different exit path: immediate, flagged, ignored and timed out.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
   localparam int OPC_W   = 4;
   localparam int NUM_OPS = 1 << OPC_W;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP   = 4'd0,
      OP_GCD   = 4'd1,
      OP_CAST  = 4'd2,
      OP_SWAP  = 4'd3,
      OP_MUL   = 4'd4,
      OP_ADD   = 4'd6,
      OP_SUB   = 4'd7,
      OP_MOVE  = 4'd12,
      OP_COPY  = 4'd13,
      OP_LOAD  = 4'd14,
      OP_STORE = 4'd15
   } opc_e;

   // bit i set when code i is in the operation map
   localparam logic [NUM_OPS-1:0] LEGAL_MASK = 16'hF0DF;
endpackage

// File: rtl/cwd_field_split.sv
module cwd_field_split #(
   parameter int WORD_W  = 32,
   parameter int OPC_LSB = 18,
   parameter int OPC_W   = 4,
   parameter int SEL_W   = 4
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [OPC_W-1:0]  opc_o,
   output logic [SEL_W-1:0]  sel_a_o,
   output logic [SEL_W-1:0]  sel_b_o,
   output logic [SEL_W-1:0]  sel_c_o
);
   localparam int SEL_TOP = 3 * SEL_W;

   generate
      if (WORD_W < OPC_LSB + OPC_W) begin : g_bad_opc
         $error("opcode field exceeds word width");
      end
      if (SEL_TOP > OPC_LSB) begin : g_bad_sel
         $error("register fields overlap opcode field");
      end
   endgenerate

   assign opc_o   = word_i[OPC_LSB +: OPC_W];
   assign sel_a_o = word_i[0 +: SEL_W];
   assign sel_b_o = word_i[SEL_W +: SEL_W];
   assign sel_c_o = word_i[2*SEL_W +: SEL_W];
endmodule

// File: rtl/cwd_op_decode.sv
module cwd_op_decode
   import cwd_pkg::*;
(
   input  logic [OPC_W-1:0]   opc_i,
   output logic [NUM_OPS-1:0] hot_o,
   output logic               legal_o,
   output logic               is_nop_o
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_OPS; gi++) begin : g_dec
         if (LEGAL_MASK[gi]) begin : g_used
            assign hot_o[gi] = (opc_i == OPC_W'(gi));
         end else begin : g_spare
            assign hot_o[gi] = 1'b0;
         end
      end
   endgenerate

   assign legal_o  = LEGAL_MASK[opc_i];
   assign is_nop_o = (opc_i == OP_NOP);
endmodule

// File: rtl/cwd_watchdog.sv
module cwd_watchdog #(
   parameter int TMO_CYC = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   output logic expired_o
);
   localparam int CNT_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

   generate
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("timeout must be at least two cycles");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) cnt_q <= '0;
      else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cwd_dispatch.sv
module cwd_dispatch
   import cwd_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int OPC_LSB = 18,
   parameter int SEL_W   = 4,
   parameter int TMO_CYC = 32
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [WORD_W-1:0]    word_i,
   input  logic                 word_vld_i,
   input  logic                 done_i,
   output logic [NUM_OPS-1:0]   op_en_o,
   output logic [SEL_W-1:0]     sel_a_o,
   output logic [SEL_W-1:0]     sel_b_o,
   output logic [SEL_W-1:0]     sel_c_o,
   output logic                 busy_o,
   output logic                 bad_op_o,
   output logic                 timeout_o
);
   logic [OPC_W-1:0]   opc_w;
   logic [SEL_W-1:0]   sa_w, sb_w, sc_w;
   logic [NUM_OPS-1:0] hot_w;
   logic               legal_w, nop_w, expired_w, accept_w;

   logic [NUM_OPS-1:0] hot_q;
   logic [SEL_W-1:0]   sa_q, sb_q, sc_q;
   logic               busy_q, nop_q, bad_q, tmo_q;

   cwd_field_split #(
      .WORD_W (WORD_W),
      .OPC_LSB(OPC_LSB),
      .OPC_W  (OPC_W),
      .SEL_W  (SEL_W)
   ) u_split (
      .word_i (word_i),
      .opc_o  (opc_w),
      .sel_a_o(sa_w),
      .sel_b_o(sb_w),
      .sel_c_o(sc_w)
   );

   cwd_op_decode u_dec (
      .opc_i   (opc_w),
      .hot_o   (hot_w),
      .legal_o (legal_w),
      .is_nop_o(nop_w)
   );

   assign accept_w = word_vld_i && !busy_q;

   cwd_watchdog #(.TMO_CYC(TMO_CYC)) u_wdog (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (accept_w),
      .run_i    (busy_q && !done_i),
      .expired_o(expired_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         hot_q  <= '0;
         sa_q   <= '0;
         sb_q   <= '0;
         sc_q   <= '0;
         nop_q  <= 1'b0;
         bad_q  <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         nop_q <= 1'b0;
         bad_q <= 1'b0;
         tmo_q <= 1'b0;
         if (accept_w) begin
            sa_q  <= sa_w;
            sb_q  <= sb_w;
            sc_q  <= sc_w;
            nop_q <= legal_w && nop_w;
            bad_q <= !legal_w;
            if (legal_w && !nop_w) begin
               busy_q <= 1'b1;
               hot_q  <= hot_w;
            end
         end else if (busy_q) begin
            if (done_i) begin
               busy_q <= 1'b0;
               hot_q  <= '0;
            end else if (expired_w) begin
               busy_q <= 1'b0;
               hot_q  <= '0;
               tmo_q  <= 1'b1;
            end
         end
      end
   end

   // completion gating: running enable drops while done is high; no-op is ungated
   always_comb begin
      op_en_o = '0;
      if (busy_q && !done_i) op_en_o = hot_q;
      op_en_o[OP_NOP] = nop_q;
   end

   assign sel_a_o   = sa_q;
   assign sel_b_o   = sb_q;
   assign sel_c_o   = sc_q;
   assign busy_o    = busy_q;
   assign bad_op_o  = bad_q;
   assign timeout_o = tmo_q;
endmodule

// File: rtl/cwd_dispatch_chk.sv
module cwd_dispatch_chk
   import cwd_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int SEL_W   = 4,
   parameter int TMO_CYC = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [WORD_W-1:0]  word_i,
   input logic               word_vld_i,
   input logic               done_i,
   input logic [NUM_OPS-1:0] op_en_o,
   input logic [SEL_W-1:0]   sel_a_o,
   input logic [SEL_W-1:0]   sel_b_o,
   input logic [SEL_W-1:0]   sel_c_o,
   input logic               busy_o,
   input logic               bad_op_o,
   input logic               timeout_o
);
   int run_len;
   always_ff @(posedge clk_i) begin
      if (!rst_ni || !busy_o) run_len <= 0;
      else run_len <= run_len + 1;
   end

   // R1
   en_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(op_en_o));

   // R5
   done_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (op_en_o[NUM_OPS-1:1] == '0));

   // R6
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && done_i) |=> !busy_o);

   // R7
   sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> ($stable(sel_a_o) && $stable(sel_b_o) && $stable(sel_c_o)));

   // R8
   nop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_en_o[0] |-> !busy_o);

   // R9
   bad_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_op_o |-> (!busy_o && op_en_o == '0));

   // R10
   tmo_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |-> (!busy_o && $past(busy_o)));

   // R10
   run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_len <= TMO_CYC);
endmodule

bind cwd_dispatch cwd_dispatch_chk #(
   .WORD_W (WORD_W),
   .SEL_W  (SEL_W),
   .TMO_CYC(TMO_CYC)
) u_chk (.*);

// File: tb/sim_cwd_dispatch.sv
`timescale 1ns/1ps
module sim_cwd_dispatch;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [31:0] word_i = '0;
   logic        word_vld_i = 1'b0;
   logic        done_i = 1'b0;
   logic [15:0] op_en_o;
   logic [3:0]  sel_a_o, sel_b_o, sel_c_o;
   logic        busy_o, bad_op_o, timeout_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk_i = ~clk_i;

   cwd_dispatch u0 (.*);

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int opc, input int c, input int b, input int a);
      return {10'd0, 4'(opc), 6'd0, 4'(c), 4'(b), 4'(a)};
   endfunction

   // drive at negedge, accept at next posedge, return at the following negedge
   task automatic send(input logic [31:0] w);
      word_i = w;
      word_vld_i = 1'b1;
      @(negedge clk_i);
      word_vld_i = 1'b0;
   endtask

   task automatic finish_cmd();
      done_i = 1'b1;
      #1;
      check("R5 gated", op_en_o, 32'h0);
      @(negedge clk_i);
      done_i = 1'b0;
      check("R6 busy", busy_o, 0);
      check("R6 en", op_en_o, 0);
   endtask

   task automatic t_reset();
      check("R11 en", op_en_o, 0);
      check("R11 busy", busy_o, 0);
      check("R11 bad", bad_op_o, 0);
      check("R11 tmo", timeout_o, 0);
      check("R11 sel", {sel_c_o, sel_b_o, sel_a_o}, 0);
   endtask

   task automatic t_map();
      int codes[10] = '{1, 2, 3, 4, 6, 7, 12, 13, 14, 15};
      foreach (codes[k]) begin
         int c = codes[k];
         send(mk(c, (c + 1) % 16, (c + 5) % 16, (c + 9) % 16));
         check("R1 busy", busy_o, 1);
         check("R2 enable", op_en_o, 32'(1) << c);
         check("R3 a", sel_a_o, (c + 9) % 16);
         check("R3 b", sel_b_o, (c + 5) % 16);
         check("R3 c", sel_c_o, (c + 1) % 16);
         @(negedge clk_i);
         check("R1 held", op_en_o, 32'(1) << c);
         finish_cmd();
      end
   endtask

   task automatic t_reserved();
      send(32'hFFC3_F5A9 & ~(32'hF << 18) | (32'd6 << 18));
      check("R4 enable", op_en_o, 32'h40);
      check("R4 sel", {sel_c_o, sel_b_o, sel_a_o}, 12'h5A9);
      finish_cmd();
   endtask

   task automatic t_nop();
      done_i = 1'b1;
      send(mk(0, 3, 2, 1));
      check("R8 pulse", op_en_o, 1);
      check("R8 busy", busy_o, 0);
      done_i = 1'b0;
      @(negedge clk_i);
      check("R8 one cycle", op_en_o, 0);
   endtask

   task automatic t_spare();
      int sp[5] = '{5, 8, 9, 10, 11};
      foreach (sp[k]) begin
         send(mk(sp[k], 1, 1, 1));
         check("R9 flag", bad_op_o, 1);
         check("R9 en", op_en_o, 0);
         check("R9 busy", busy_o, 0);
         @(negedge clk_i);
         check("R9 pulse end", bad_op_o, 0);
      end
   endtask

   task automatic t_busy_ignore();
      send(mk(4, 7, 6, 5));
      send(mk(6, 1, 2, 3));
      check("R7 en", op_en_o, 32'h10);
      check("R7 sel", {sel_c_o, sel_b_o, sel_a_o}, 12'h765);
      finish_cmd();
   endtask

   task automatic t_timeout();
      int busy_cnt = 0;
      send(mk(1, 2, 2, 2));
      for (int i = 0; i < 40 && busy_o; i++) begin
         busy_cnt++;
         check("R10 no early flag", timeout_o, 0);
         @(negedge clk_i);
      end
      check("R10 length", busy_cnt, 32);
      check("R10 flag", timeout_o, 1);
      check("R10 en", op_en_o, 0);
      @(negedge clk_i);
      check("R10 pulse end", timeout_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_map();
      t_reserved();
      t_nop();
      t_spare();
      t_busy_ignore();
      t_timeout();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule